// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block orders the entry into and the exit from a low-power state of a clock generator. A single active-low power-down pin, which may change at any time, is first brought through a synchronizer. Once the request is seen, the block closes the gates of the CPU and PCI clock groups. Each gate closes only while its source clock is low. Only when both gates are closed does it raise the shutdown enables for the PLLs and the crystal oscillator. When the pin is released, the shutdown enables drop, and a settle counter of programmable length runs before the gates may open again. Each gate again opens only on a low phase of its own source.

The block runs on a core clock. It samples the two internal source clocks as free-running phase signals that change on core clock edges. Outside this block, each group's output clock is formed as the AND of its source and its gate enable. Two further active-low inputs stop the CPU group or the PCI group on their own during normal running. Both inputs are ignored while a power-down is under way. The reference clock gate is not part of the ordered sequence. It closes as soon as the synchronized request appears and reopens when the sequence returns to normal running.

Top module: `clk_pwrdn_seq`

## Requirements
- R1: `pd_n`, `cpu_stop_n` and `pci_stop_n` each pass through a two-flop synchronizer. A low level on `pd_n` that is present at a rising edge turns `ref_en` low after the second rising edge, and not after the first.
- R2: Each gate enable changes only at an edge where its source clock was sampled low. So every high pulse of `source AND gate` lasts a full source half-period, with no shortened or stretched pulse.
- R3: `osc_off` is never high while `cpu_gate_en` or `pci_gate_en` is high.
- R4: After the synchronized request appears, `cpu_gate_en` falls within three CPU source periods. `osc_off` and `pll_off` then assert once both gates are low.
- R5: `pll_off` and `osc_off` assert together, and they stay high for as long as the synchronized request stays asserted.
- R6: After the request is released, `osc_off` and `pll_off` fall. `ref_en` rises exactly `SETTLE_CYCLES` core cycles later, and both gates stay closed until then. Afterwards each gate reopens within one period of its source.
- R7: While a power-down is in progress (from the synchronized request until the sequence is back in normal running), the stop inputs have no effect. No gate opens, and `osc_off` keeps its value.
- R8: In normal running, `cpu_stop_n` low closes only the CPU gate and `pci_stop_n` low closes only the PCI gate. Neither affects `osc_off` or `ref_en`, and releasing the stop reopens the gate.
- R9: A request that is seen in the last settle cycle takes priority over finishing the settle. The block returns to the shutdown state, `osc_off` goes high again at that edge, and `ref_en` stays low.
- R10: During and just after reset, both gates are closed, `osc_off` and `pll_off` are low and `ref_en` is high. Both gates open within one source period after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_src | input | 1 | CPU group source clock phase, changes on core edges |
| pci_src | input | 1 | PCI group source clock phase, changes on core edges |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_n | input | 1 | Asynchronous active-low CPU group stop |
| pci_stop_n | input | 1 | Asynchronous active-low PCI group stop |
| cpu_gate_en | output | 1 | CPU group clock gate enable |
| pci_gate_en | output | 1 | PCI group clock gate enable |
| ref_en | output | 1 | Reference clock gate enable |
| pll_off | output | 1 | PLL shutdown enable |
| osc_off | output | 1 | Crystal oscillator shutdown enable |

## Verification
The sharpest collision is a fresh power-down request arriving in the very cycle the settle counter completes. The two transitions out of the settle state then compete for the same edge. The bench counts core edges from the fall of `osc_off` and places the `pd_n` edge so that the synchronizer delivers it exactly at the final settle cycle. It then expects `osc_off` high again and `ref_en` still low right after that edge. A second overlap, a stop input toggling in the middle of a shutdown, is driven at random during both the off and settle phases and judged by the gates staying shut.

// File: rtl/clk_pwrdn_pkg.sv
// Shared types for the clock power-down sequencer.
package clk_pwrdn_pkg;

    // Sequencer states: normal running, closing gates, shut down, settling.
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_GATE_LOW = 2'd1,
        ST_OFF      = 2'd2,
        ST_SETTLE   = 2'd3
    } pd_state_e;

    // Index of each controlled clock group inside the group vectors.
    localparam int unsigned GRP_CPU  = 0;
    localparam int unsigned GRP_PCI  = 1;
    localparam int unsigned NUM_GRPS = 2;

endpackage

// File: rtl/clk_pwrdn_sync.sv
// Multi-bit level synchronizer for asynchronous active-low control pins.
// Assumes each bit is an independent level (no bus coherence needed) and
// that the idle value of every input is high, so reset loads all ones.
module clk_pwrdn_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the sampled pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '1;
            end
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/clk_pwrdn_gate.sv
// Gate-enable register for one clock group.
// Assumes src_i is the group's source clock phase, updated on core edges.
// The enable is only reloaded when the source was low, so the AND of
// source and enable never yields a partial high pulse.
module clk_pwrdn_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic allow_i,
    output logic gate_o
);

    logic gate_q;

    // Follow the allow request, but only during a low source phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (!src_i) begin
            gate_q <= allow_i;
        end
    end

    assign gate_o = gate_q;

    // R2: the enable moves only after an edge where the source was low.
    a_r2_change_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q != $past(gate_q)) |-> !$past(src_i));

endmodule

// File: rtl/clk_pwrdn_settle.sv
// Settle interval counter used on power-down exit.
// Assumes CYCLES >= 2. While en is high it counts up once per core cycle
// and holds at the last value; done marks that last cycle.
module clk_pwrdn_settle #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic done
);

    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count settle cycles; clear whenever the settle phase is not active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = en && (cnt_q == LAST);

    // R6: while settling and not finished, the count advances by one.
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !done) |=> (!en || (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/clk_pwrdn_seq.sv
// Clock power-down sequencer top.
// Synchronizes the power-down and group-stop pins, closes the CPU and PCI
// gates on low source phases, then raises the PLL and oscillator shutdown
// enables. On release it waits SETTLE_CYCLES before gates may reopen.
// Assumes cpu_src and pci_src are free-running phases in the clk domain.
module clk_pwrdn_seq #(
    parameter int SETTLE_CYCLES = 40,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_src,
    input  logic pci_src,
    input  logic pd_n,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    output logic cpu_gate_en,
    output logic pci_gate_en,
    output logic ref_en,
    output logic pll_off,
    output logic osc_off
);

    import clk_pwrdn_pkg::*;

    localparam int NPINS = NUM_GRPS + 1;

    logic [NPINS-1:0]    pins_sync;
    logic                pd_req;
    logic [NUM_GRPS-1:0] stop_req;
    logic [NUM_GRPS-1:0] src_vec;
    logic [NUM_GRPS-1:0] gate_vec;
    logic                run_allow;
    logic                settle_done;
    logic                pwr_off;
    pd_state_e           state_q;
    pd_state_e           state_d;

    // Bring all three asynchronous pins into the core domain.
    clk_pwrdn_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pci_stop_n, cpu_stop_n, pd_n}),
        .sync_o  (pins_sync)
    );

    assign pd_req             = ~pins_sync[0];
    assign stop_req[GRP_CPU]  = ~pins_sync[1 + GRP_CPU];
    assign stop_req[GRP_PCI]  = ~pins_sync[1 + GRP_PCI];
    assign src_vec[GRP_CPU]   = cpu_src;
    assign src_vec[GRP_PCI]   = pci_src;

    // Gates may be open only in normal running with no pending request.
    assign run_allow = (state_q == ST_RUN) && !pd_req;

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
        clk_pwrdn_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_vec[g]),
            .allow_i (run_allow && !stop_req[g]),
            .gate_o  (gate_vec[g])
        );
    end

    clk_pwrdn_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_SETTLE),
        .done  (settle_done)
    );

    // Next-state decode of the power-down sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (pd_req) state_d = ST_GATE_LOW;
            ST_GATE_LOW: if (gate_vec == '0) state_d = ST_OFF;
            ST_OFF:      if (!pd_req) state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (pd_req)           state_d = ST_OFF;
                else if (settle_done) state_d = ST_RUN;
            end
            default:     state_d = ST_RUN;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    assign pwr_off     = (state_q == ST_OFF);
    assign pll_off     = pwr_off;
    assign osc_off     = pwr_off;
    assign ref_en      = run_allow;
    assign cpu_gate_en = gate_vec[GRP_CPU];
    assign pci_gate_en = gate_vec[GRP_PCI];

    // R3: shutdown enables never coexist with an open group gate.
    a_r3_off_gates_low: assert property (@(posedge clk) disable iff (!rst_n)
        osc_off |-> (!cpu_gate_en && !pci_gate_en));

    // R5: once shut down, a held request keeps the oscillator off.
    a_r5_off_held: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_off && pd_req) |=> osc_off);

    // R7: outside normal running no gate may open, whatever the stop pins do.
    a_r7_no_open_when_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> (!$rose(cpu_gate_en) && !$rose(pci_gate_en)));

    // R9: a request during settle sends the sequence back to shutdown.
    a_r9_settle_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && pd_req) |=> (state_q == ST_OFF));

endmodule

// File: tb/clk_pwrdn_seq_tb.sv
module clk_pwrdn_seq_tb;

    localparam int S  = 40;
    localparam int HC = 2;
    localparam int HP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_src = 1'b0;
    logic pci_src = 1'b0;
    logic pd_n = 1'b1;
    logic cpu_stop_n = 1'b1;
    logic pci_stop_n = 1'b1;
    logic cpu_gate_en, pci_gate_en, ref_en, pll_off, osc_off;

    int checks = 0;
    int errors = 0;
    int cdiv = 0;
    int pdiv = 0;

    clk_pwrdn_seq #(.SETTLE_CYCLES(S), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src),
        .pd_n(pd_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .cpu_gate_en(cpu_gate_en), .pci_gate_en(pci_gate_en),
        .ref_en(ref_en), .pll_off(pll_off), .osc_off(osc_off)
    );

    always #4 clk = ~clk;

    // Free-running source phases in the core clock domain.
    always @(posedge clk) begin
        if (cdiv == HC - 1) begin cdiv <= 0; cpu_src <= ~cpu_src; end
        else cdiv <= cdiv + 1;
        if (pdiv == HP - 1) begin pdiv <= 0; pci_src <= ~pci_src; end
        else pdiv <= pdiv + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected high-pulse width of a gated group from its half-period.
    function automatic int exp_width(input int half);
        return half;
    endfunction

    // Continuous monitors: pulse widths, ordering, settle length, park latency.
    int cpu_w = 0, pci_w = 0, sc = 0, park_cnt = 0;
    bit meas = 0, park_meas = 0;
    logic osc_prev = 1'b0, ref_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_src && cpu_gate_en) cpu_w++;
            else if (cpu_w != 0) begin
                chk(cpu_w == exp_width(HC), "R2 cpu gated pulse width", cpu_w, HC);
                cpu_w = 0;
            end
            if (pci_src && pci_gate_en) pci_w++;
            else if (pci_w != 0) begin
                chk(pci_w == exp_width(HP), "R2 pci gated pulse width", pci_w, HP);
                pci_w = 0;
            end
            if (osc_off && (cpu_gate_en || pci_gate_en))
                chk(1'b0, "R3 osc_off with open gate", 1, 0);
            if (meas) begin
                sc++;
                if (osc_off) meas = 0;
                else if (ref_en) begin
                    chk(sc == S, "R6 settle length", sc, S);
                    meas = 0;
                end
            end
            if (osc_prev && !osc_off) begin meas = 1; sc = 0; end
            if (ref_prev && !ref_en) begin park_meas = 1; park_cnt = 0; end
            else if (park_meas) park_cnt++;
            if (park_meas && !cpu_gate_en) begin
                chk(park_cnt <= 6 * HC, "R4 cpu park latency", park_cnt, 6 * HC);
                park_meas = 0;
            end
            osc_prev = osc_off;
            ref_prev = ref_en;
        end else begin
            cpu_w = 0; pci_w = 0; meas = 0; park_meas = 0;
            osc_prev = 1'b0; ref_prev = 1'b1;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog.
    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    task automatic wait_osc(input logic val);
        for (int i = 0; i < 500 && osc_off !== val; i++) @(negedge clk);
    endtask

    task automatic wait_run();
        for (int i = 0; i < S + 200 && ref_en !== 1'b1; i++) @(negedge clk);
        repeat (2 * HP + 2) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED);

        // R10: reset state.
        repeat (5) @(negedge clk);
        chk(cpu_gate_en == 0 && pci_gate_en == 0, "R10 gates closed in reset", cpu_gate_en + pci_gate_en, 0);
        chk(osc_off == 0 && pll_off == 0, "R10 shutdown low in reset", osc_off + pll_off, 0);
        chk(ref_en == 1, "R10 ref_en high in reset", ref_en, 1);
        rst_n = 1'b1;
        repeat (2 * HP + 2) @(negedge clk);
        chk(cpu_gate_en && pci_gate_en, "R10 gates open after reset", cpu_gate_en + pci_gate_en, 2);

        // R1: two-edge synchronizer latency.
        pd_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(ref_en == 1, "R1 no effect after first edge", ref_en, 1);
        @(posedge clk); @(negedge clk);
        chk(ref_en == 0, "R1 effect after second edge", ref_en, 0);

        // R4/R5: shutdown reached with both enables.
        wait_osc(1'b1);
        chk(osc_off == 1, "R4 shutdown reached", osc_off, 1);
        chk(pll_off == 1, "R5 pll_off with osc_off", pll_off, 1);

        // R7: stop pins toggled during shutdown have no effect.
        for (int i = 0; i < 20; i++) begin
            cpu_stop_n = 1'($urandom_range(0, 1));
            pci_stop_n = 1'($urandom_range(0, 1));
            @(negedge clk);
            chk(osc_off == 1 && pll_off == 1, "R7 shutdown kept under stop toggles", osc_off, 1);
            chk(!cpu_gate_en && !pci_gate_en, "R7 gates stay closed", cpu_gate_en + pci_gate_en, 0);
        end
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1;

        // R6: release and recover.
        pd_n = 1'b1;
        wait_run();
        chk(cpu_gate_en && pci_gate_en, "R6 gates reopen after settle", cpu_gate_en + pci_gate_en, 2);

        // R8: single-group stops in normal running.
        cpu_stop_n = 1'b0;
        repeat (2 * HC + 4) @(negedge clk);
        chk(!cpu_gate_en && pci_gate_en, "R8 cpu stop closes only cpu", {cpu_gate_en, pci_gate_en}, 1);
        chk(!osc_off && ref_en, "R8 cpu stop leaves osc/ref", {osc_off, ref_en}, 1);
        cpu_stop_n = 1'b1;
        repeat (2 * HC + 4) @(negedge clk);
        chk(cpu_gate_en == 1, "R8 cpu gate reopens", cpu_gate_en, 1);
        pci_stop_n = 1'b0;
        repeat (2 * HP + 4) @(negedge clk);
        chk(cpu_gate_en && !pci_gate_en, "R8 pci stop closes only pci", {cpu_gate_en, pci_gate_en}, 2);
        pci_stop_n = 1'b1;
        repeat (2 * HP + 4) @(negedge clk);
        chk(pci_gate_en == 1, "R8 pci gate reopens", pci_gate_en, 1);

        // R9: request lands in the final settle cycle.
        pd_n = 1'b0;
        wait_osc(1'b1);
        @(negedge clk);
        pd_n = 1'b1;
        wait_osc(1'b0);
        repeat (S - 3) @(posedge clk);
        @(negedge clk);
        pd_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(osc_off == 1, "R9 re-entry wins over settle end", osc_off, 1);
        chk(ref_en == 0, "R9 ref stays off on re-entry", ref_en, 0);
        pd_n = 1'b1;
        wait_run();
        chk(cpu_gate_en && pci_gate_en, "R9 recovery after re-entry", cpu_gate_en + pci_gate_en, 2);

        // Random mix of power-down pulses and stop toggles.
        for (int it = 0; it < 25; it++) begin
            int run_len, pd_len;
            run_len = $urandom_range(5, 30);
            pd_len  = $urandom_range(1, 50);
            for (int i = 0; i < run_len; i++) begin
                cpu_stop_n = ($urandom_range(0, 3) != 0);
                pci_stop_n = ($urandom_range(0, 3) != 0);
                @(negedge clk);
            end
            pd_n = 1'b0;
            for (int i = 0; i < pd_len; i++) begin
                cpu_stop_n = ($urandom_range(0, 1) != 0);
                pci_stop_n = ($urandom_range(0, 1) != 0);
                @(negedge clk);
            end
            pd_n = 1'b1;
            for (int i = 0; i < S + 40; i++) begin
                cpu_stop_n = ($urandom_range(0, 3) != 0);
                pci_stop_n = ($urandom_range(0, 3) != 0);
                @(negedge clk);
            end
            cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
            wait_run();
            chk(!osc_off && ref_en && cpu_gate_en && pci_gate_en, "R6 recovery after random cycle",
                {osc_off, ref_en, cpu_gate_en, pci_gate_en}, 7);
        end

        summary();
        $finish;
    end

endmodule